// File: doc/BRIEF.md
# Host Bridge Control Register File

This block holds the software-visible control state of a PCI host bridge. A processor reaches it over a simple 32-bit register bus. The bus has one request per cycle, and read data comes back registered one cycle later. Only the low 16 address bits are decoded. Inside that window the block holds four groups of registers:

- three address-translation control words;
- twelve plain PCI control words;
- eight interrupt-map entries, whose enable bits drive an interrupt router directly;
- a reset control/status register.

Offsets that belong to no implemented group read as zero, and writes to them are dropped.

The reset register keeps a history across bridge resets. A saturating counter records how many bridge resets have happened since the counter was last cleared. The power-on flag is latched only by a bridge reset that finds this counter at zero. Software can ask for a system reset by writing one of two trigger bits. The block answers with a one-cycle request pulse. The soft power-on trigger also clears the counter, so the next bridge reset is again seen as a power-on.

Top module: `hb_regfile`

## Requirements
- R1: After `rst`, the interrupt-map entry i reads (0x1F << 6) | (i << 2), and all other registers read zero. `sys_rst_req` is low and `imap_en` is all zero.
- R2: The translation words at offsets 0x200, 0x204 and 0x208 store and return all 32 bits of the data written to them.
- R3: The PCI control words at offsets 0x2000 to 0x202C (step 4) store and return all 32 bits of the data written to them.
- R4: Interrupt-map entry i sits at offset 0xC04 + 8*i. A write there changes only bit 31. Bits 30:0 keep their value. The even words 0xC00 + 8*i read zero, and writes to them are ignored.
- R5: `imap_en[i]` equals bit 31 of interrupt-map entry i. It changes in the cycle after the write is accepted.
- R6: A cycle with `brg_rst` high clears bit 31 of every interrupt-map entry and keeps bits 30:0.
- R7: The reset register sits at offset 0xF024, and offset 0xF020 reads zero. Written data is first masked to bits 31:27. A 1 in bit 31, 28 or 27 clears that bit. A 1 in bit 30 or 29 sets that bit, and a 0 there leaves the bit unchanged. Bits 26:0 read zero.
- R8: A write to the reset register with bit 30 set does two things. It raises `sys_rst_req` for exactly the one cycle after the write, and it clears the bridge-reset counter.
- R9: A write to the reset register with bit 29 set and bit 30 clear raises the same one-cycle pulse. A write with both bits clear raises no pulse.
- R10: A bridge reset that finds the counter at zero sets the reset register to 0x80000000. Otherwise the register is left unchanged. The counter then increments and saturates at 2^CNT_W - 1 rather than wrapping.
- R11: Offsets 0x30 to 0x4F, 0x20C to 0x3FF, the diagnostic areas and all other unmapped offsets read zero. Writes to them change no register.
- R12: A read request returns `rd_valid` high with its data in the next cycle. While `rd_valid` is low, `rd_data` is zero.
- R13: When `brg_rst` and a register write arrive in the same cycle, the bridge reset takes effect. The write to the interrupt-map entries or to the reset register is dropped, and no request pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| brg_rst | input | 1 | Bridge reset event, one cycle per reset |
| req_valid | input | 1 | Register request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the request; the low 16 bits are decoded |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 32 | Read data; zero when `rd_valid` is low |
| sys_rst_req | output | 1 | One-cycle system reset request |
| imap_en | output | NUM_IMAP | Enable bit of each interrupt-map entry |

## Verification
A wrong counter value shows up late. It appears only at the next bridge reset, when the power-on flag latches or fails to latch. For that reason the bench clears the flag and then issues more bridge resets than the counter can count without wrapping. A lost or extra write to the reset register changes the sticky trigger bits and the `sys_rst_req` pulse in the very next cycle. Corrupted low bits of an interrupt-map entry are seen only on a readback. `imap_en` exposes only bit 31, one cycle after each write or bridge reset.

// File: rtl/hb_regfile_pkg.sv
package hb_regfile_pkg;

  localparam int DW = 32;

  // decoded request target
  typedef struct packed {
    logic       xlt;
    logic       imap;
    logic       pctl;
    logic       rctl;
    logic [3:0] idx;
  } hb_dec_t;

  // window bounds (low 16 bits of the offset)
  localparam logic [15:0] XLT_LO  = 16'h0200;
  localparam logic [15:0] XLT_HI  = 16'h020B;
  localparam logic [15:0] IMAP_LO = 16'h0C00;
  localparam logic [15:0] IMAP_HI = 16'h0C3F;
  localparam logic [15:0] PCTL_LO = 16'h2000;
  localparam logic [15:0] PCTL_HI = 16'h202F;
  localparam logic [15:0] RCTL_LO = 16'hF020;
  localparam logic [15:0] RCTL_HI = 16'hF027;

  // reset register bit classes
  localparam logic [DW-1:0] RC_DEFINED = 32'hF800_0000;
  localparam logic [DW-1:0] RC_CLR1    = 32'h9800_0000;
  localparam logic [DW-1:0] RC_SET1    = 32'h6000_0000;
  localparam logic [DW-1:0] RC_POWERON = 32'h8000_0000;
  localparam int RC_SOFT_PWR = 30;
  localparam int RC_SOFT_INT = 29;

  function automatic logic [DW-1:0] imap_init(input int unsigned i);
    return 32'h0000_07C0 | (32'(i) << 2);
  endfunction

endpackage

// File: rtl/hb_decode.sv
module hb_decode
  import hb_regfile_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output hb_dec_t           dec
);
  logic [15:0] a;
  assign a = addr[15:0];

  always_comb begin
    dec      = '0;
    dec.xlt  = (a >= XLT_LO)  && (a <= XLT_HI);
    dec.imap = (a >= IMAP_LO) && (a <= IMAP_HI) && a[2];
    dec.pctl = (a >= PCTL_LO) && (a <= PCTL_HI);
    dec.rctl = (a >= RCTL_LO) && (a <= RCTL_HI) && a[2];
    dec.idx  = dec.imap ? {1'b0, a[5:3]} : a[5:2];
  end
endmodule

// File: rtl/hb_imap.sv
module hb_imap
  import hb_regfile_pkg::*;
#(
  parameter int NUM_IMAP = 8,
  localparam int IW = $clog2(NUM_IMAP)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     brg_rst,
  input  logic                     wr_en,
  input  logic [IW-1:0]            wr_idx,
  input  logic                     wr_enable_bit,
  output logic [NUM_IMAP-1:0][DW-1:0] entry,
  output logic [NUM_IMAP-1:0]      en
);
  for (genvar g = 0; g < NUM_IMAP; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        entry[g] <= imap_init(g);
      end else if (brg_rst) begin
        entry[g][DW-1] <= 1'b0;
      end else if (wr_en && (wr_idx == IW'(g))) begin
        entry[g][DW-1] <= wr_enable_bit;
      end
    end
    assign en[g] = entry[g][DW-1];

    AST_LOW_BITS_KEPT: assert property (@(posedge clk) disable iff (rst)
      $stable(entry[g][DW-2:0])); // R4
  end

  AST_BRG_CLEARS_EN: assert property (@(posedge clk) disable iff (rst)
    brg_rst |=> (en == '0)); // R6
endmodule

// File: rtl/hb_rstctl.sv
module hb_rstctl
  import hb_regfile_pkg::*;
#(
  parameter int CNT_W = 4,
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}}
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          brg_rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ctl,
  output logic          sys_rst_req
);
  logic [CNT_W-1:0] cnt;
  logic [DW-1:0]    m;

  assign m = wdata & RC_DEFINED;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl         <= '0;
      cnt         <= '0;
      sys_rst_req <= 1'b0;
    end else begin
      sys_rst_req <= 1'b0;
      if (brg_rst) begin
        if (cnt == '0) ctl <= RC_POWERON;
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      end else if (wr_en) begin
        ctl <= (ctl & ~(m & RC_CLR1)) | (m & RC_SET1);
        if (m[RC_SOFT_PWR]) cnt <= '0;
        if (m[RC_SOFT_PWR] || m[RC_SOFT_INT]) sys_rst_req <= 1'b1;
      end
    end
  end

  AST_LATE_BRG_KEEPS_CTL: assert property (@(posedge clk) disable iff (rst)
    (brg_rst && cnt != '0) |=> $stable(ctl)); // R10
  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (cnt == CNT_MAX && !wr_en) |=> (cnt == CNT_MAX)); // R10
  AST_REQ_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
    sys_rst_req |-> $past(wr_en && !brg_rst)); // R8
  AST_DEFINED_ONLY: assert property (@(posedge clk) disable iff (rst)
    (ctl & ~RC_DEFINED) == '0); // R7
endmodule

// File: rtl/hb_regfile.sv
module hb_regfile
  import hb_regfile_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int NUM_XLT  = 3,
  parameter int NUM_PCTL = 12,
  parameter int NUM_IMAP = 8,
  parameter int CNT_W    = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                brg_rst,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DW-1:0]       req_wdata,
  output logic                rd_valid,
  output logic [DW-1:0]       rd_data,
  output logic                sys_rst_req,
  output logic [NUM_IMAP-1:0] imap_en
);
  localparam int IW = $clog2(NUM_IMAP);
  localparam int XW = $clog2(NUM_XLT);

  hb_dec_t dec;
  logic    wr, rd;
  logic [DW-1:0] xlt  [NUM_XLT];
  logic [DW-1:0] pctl [NUM_PCTL];
  logic [NUM_IMAP-1:0][DW-1:0] imap_ent;
  logic [DW-1:0] rc_val;
  logic [DW-1:0] rd_mux;

  assign wr = req_valid && req_write;
  assign rd = req_valid && !req_write;

  hb_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (req_addr),
    .dec  (dec)
  );

  for (genvar g = 0; g < NUM_XLT; g++) begin : g_xlt
    always_ff @(posedge clk) begin
      if (rst) xlt[g] <= '0;
      else if (wr && dec.xlt && dec.idx[XW-1:0] == XW'(g)) xlt[g] <= req_wdata;
    end
  end

  for (genvar g = 0; g < NUM_PCTL; g++) begin : g_pctl
    always_ff @(posedge clk) begin
      if (rst) pctl[g] <= '0;
      else if (wr && dec.pctl && dec.idx == 4'(g)) pctl[g] <= req_wdata;
    end
  end

  hb_imap #(.NUM_IMAP(NUM_IMAP)) u_imap (
    .clk           (clk),
    .rst           (rst),
    .brg_rst       (brg_rst),
    .wr_en         (wr && dec.imap),
    .wr_idx        (dec.idx[IW-1:0]),
    .wr_enable_bit (req_wdata[DW-1]),
    .entry         (imap_ent),
    .en            (imap_en)
  );

  hb_rstctl #(.CNT_W(CNT_W)) u_rst (
    .clk         (clk),
    .rst         (rst),
    .brg_rst     (brg_rst),
    .wr_en       (wr && dec.rctl),
    .wdata       (req_wdata),
    .ctl         (rc_val),
    .sys_rst_req (sys_rst_req)
  );

  always_comb begin
    rd_mux = '0;
    if (dec.xlt)       rd_mux = xlt[dec.idx[XW-1:0]];
    else if (dec.imap) rd_mux = imap_ent[dec.idx[IW-1:0]];
    else if (dec.pctl) rd_mux = pctl[dec.idx];
    else if (dec.rctl) rd_mux = rc_val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd;
      rd_data  <= rd ? rd_mux : '0;
    end
  end

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
    rd |=> rd_valid); // R12
  AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> (rd_data == '0)); // R12
  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (sys_rst_req && !$past(wr)) |=> !sys_rst_req); // R8
endmodule

// File: tb/hb_regfile_tb.sv
`timescale 1ns/1ps
module hb_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        brg_rst = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        sys_rst_req;
  logic [7:0]  imap_en;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference model
  logic [31:0] m_xlt [3];
  logic [31:0] m_pctl [12];
  logic [31:0] m_imap [8];
  logic [31:0] m_rc;
  int          m_cnt;

  always #4 clk = ~clk;

  hb_regfile dut_i (
    .clk(clk), .rst(rst), .brg_rst(brg_rst), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .sys_rst_req(sys_rst_req),
    .imap_en(imap_en)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit in_xlt(logic [15:0] a);  return a >= 16'h200 && a <= 16'h20B; endfunction
  function automatic bit in_imap(logic [15:0] a); return a >= 16'hC00 && a <= 16'hC3F && a[2]; endfunction
  function automatic bit in_pctl(logic [15:0] a); return a >= 16'h2000 && a <= 16'h202F; endfunction
  function automatic bit in_rc(logic [15:0] a);   return a == 16'hF024; endfunction

  function automatic logic [31:0] exp_read(logic [15:0] a);
    if (in_xlt(a))  return m_xlt[a[3:2]];
    if (in_imap(a)) return m_imap[a[5:3]];
    if (in_pctl(a)) return m_pctl[a[5:2]];
    if (in_rc(a))   return m_rc;
    return 32'h0;
  endfunction

  function automatic logic [7:0] exp_en();
    logic [7:0] e;
    for (int i = 0; i < 8; i++) e[i] = m_imap[i][31];
    return e;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 3; i++) m_xlt[i] = 0;
    for (int i = 0; i < 12; i++) m_pctl[i] = 0;
    for (int i = 0; i < 8; i++) m_imap[i] = 32'h7C0 | (i << 2);
    m_rc = 0;
    m_cnt = 0;
  endtask

  task automatic model_write(logic [15:0] a, logic [31:0] d);
    logic [31:0] v;
    if (in_xlt(a))  m_xlt[a[3:2]] = d;
    if (in_pctl(a)) m_pctl[a[5:2]] = d;
    if (in_imap(a)) m_imap[a[5:3]][31] = d[31];
    if (in_rc(a)) begin
      v = d & 32'hF800_0000;
      m_rc = (m_rc & ~(v & 32'h9800_0000)) | (v & 32'h6000_0000);
      if (v[30]) m_cnt = 0;
    end
  endtask

  task automatic model_brg();
    for (int i = 0; i < 8; i++) m_imap[i][31] = 1'b0;
    if (m_cnt == 0) m_rc = 32'h8000_0000;
    if (m_cnt < 15) m_cnt++;
  endtask

  task automatic do_wr(logic [15:0] a, logic [31:0] d);
    logic exp_p;
    exp_p = in_rc(a) && (d[30] || d[29]);
    @(negedge clk);
    chk("R8 pulse lasts one cycle", {31'b0, sys_rst_req}, 32'h0);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
    model_write(a, d);
    chk(exp_p ? "R8/R9 request pulse" : "R9 no request pulse", {31'b0, sys_rst_req}, {31'b0, exp_p});
    chk("R5 imap_en after write", {24'b0, imap_en}, {24'b0, exp_en()});
  endtask

  task automatic do_rd(logic [15:0] a, string tag);
    @(negedge clk);
    chk("R8 pulse lasts one cycle", {31'b0, sys_rst_req}, 32'h0);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    chk("R12 rd_valid", {31'b0, rd_valid}, 32'h1);
    chk(tag, rd_data, exp_read(a));
  endtask

  task automatic do_brg(bit with_write, logic [15:0] a, logic [31:0] d);
    @(negedge clk);
    brg_rst = 1;
    if (with_write) begin
      req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    end
    @(negedge clk);
    brg_rst = 0; req_valid = 0; req_write = 0;
    model_brg();
    if (with_write && !in_imap(a) && !in_rc(a)) model_write(a, d);
    chk("R13 no pulse on bridge reset", {31'b0, sys_rst_req}, 32'h0);
    chk("R6 imap_en cleared", {24'b0, imap_en}, {24'b0, exp_en()});
  endtask

  function automatic logic [15:0] pick_addr();
    logic [15:0] un [10] = '{16'h0030, 16'h004C, 16'h020C, 16'h03FC, 16'h5000,
                             16'hA400, 16'hA800, 16'hF000, 16'h1234, 16'hFFFC};
    case ($urandom % 5)
      0: return 16'h200 + 16'(4 * ($urandom % 3));
      1: return 16'hC00 + 16'(4 * ($urandom % 16));
      2: return 16'h2000 + 16'(4 * ($urandom % 12));
      3: return ($urandom % 2) ? 16'hF024 : 16'hF020;
      default: return un[$urandom % 10];
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R12 watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 sys_rst_req", {31'b0, sys_rst_req}, 32'h0);
    chk("R1 imap_en", {24'b0, imap_en}, 32'h0);
    chk("R12 rd_data idle", rd_data, 32'h0);
    for (int i = 0; i < 8; i++) do_rd(16'hC04 + 16'(8 * i), "R1 imap reset value");
    do_rd(16'hC1C, "R1 imap entry 3");
    chk("R1 entry 3 literal", rd_data, 32'h0000_07CC);
    do_rd(16'hF024, "R1 reset register");
    do_rd(16'h0204, "R1 translation word");
    // R2, R3
    do_wr(16'h0208, 32'hDEAD_BEEF);
    do_rd(16'h0208, "R2 translation word 2");
    chk("R2 literal", rd_data, 32'hDEAD_BEEF);
    do_wr(16'h202C, 32'h1234_5678);
    do_rd(16'h202C, "R3 last PCI control word");
    // R4, R5
    do_wr(16'h0C0C, 32'hFFFF_FFFF);
    do_rd(16'h0C0C, "R4 only bit 31 written");
    chk("R4 literal", rd_data, 32'h8000_07C4);
    chk("R5 enable bit 1", {24'b0, imap_en}, 32'h0000_0002);
    do_wr(16'h0C08, 32'hFFFF_FFFF);
    do_rd(16'h0C08, "R4 even word reads zero");
    do_wr(16'h0C3C, 32'h8000_0000);
    // R6 and first bridge reset R10
    do_brg(0, 16'h0, 32'h0);
    do_rd(16'h0C0C, "R6 low bits kept");
    chk("R6 literal", rd_data, 32'h0000_07C4);
    do_rd(16'hF024, "R10 power-on latched");
    chk("R10 literal", rd_data, 32'h8000_0000);
    // R7
    do_rd(16'hF020, "R7 even word zero");
    do_wr(16'hF024, 32'h8000_0000);
    do_rd(16'hF024, "R7 W1C bit 31");
    do_wr(16'hF024, 32'h0800_0000);
    do_wr(16'hF024, 32'h2000_0000);
    do_rd(16'hF024, "R9 soft interrupt bit set");
    chk("R9 literal", rd_data, 32'h2000_0000);
    do_wr(16'hF024, 32'h07FF_FFFF);
    do_rd(16'hF024, "R7 undefined bits ignored");
    // R8 soft power-on then bridge reset latches again
    do_wr(16'hF024, 32'h4000_0000);
    do_brg(0, 16'h0, 32'h0);
    do_rd(16'hF024, "R8 counter cleared, power-on again");
    chk("R8 literal", rd_data, 32'h8000_0000);
    // R10 saturation: many bridge resets without wrap
    do_wr(16'hF024, 32'h8000_0000);
    for (int i = 0; i < 20; i++) do_brg(0, 16'h0, 32'h0);
    do_rd(16'hF024, "R10 counter saturates");
    chk("R10 no wrap literal", rd_data, 32'h0);
    // R13 simultaneous bridge reset and write
    do_brg(1, 16'h0C04, 32'h8000_0000);
    do_rd(16'h0C04, "R13 write dropped");
    do_brg(1, 16'hF024, 32'h6000_0000);
    do_rd(16'hF024, "R13 reset register write dropped");
    // R11 unmapped writes
    do_wr(16'h0030, 32'hFFFF_FFFF);
    do_wr(16'h020C, 32'hFFFF_FFFF);
    do_wr(16'hA800, 32'hFFFF_FFFF);
    do_rd(16'h0030, "R11 unmapped reads zero");
    do_rd(16'h020C, "R11 flush area reads zero");
    do_rd(16'h0200, "R11 neighbours untouched");
    // random phase
    for (int n = 0; n < 600; n++) begin
      logic [15:0] a;
      int op;
      a = pick_addr();
      op = $urandom % 10;
      if (op < 4) do_wr(a, $urandom);
      else if (op < 9) do_rd(a, "R11 random read vs model");
      else do_brg(($urandom % 2) == 1, a, $urandom);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule